// File: doc/BRIEF.md
# Complementary PWM Pair Output Stage

This block sits between a counter/compare unit and the two output pins of one channel pair. It receives a single reference PWM waveform and produces the levels for channel 0 (even) and channel 1 (odd) of the pair. Channel 1 is either a copy of the reference or its complement. Both channels can receive dead time, which holds back each rising edge so that the two switches of a half bridge are never on together.

After dead time, the waveform passes through a fixed chain of stages. In order, these are: pair inversion, per-channel software override, per-channel mask, fault shutdown, and per-channel output polarity. The final pin level is registered.

Up to four fault inputs are monitored. Each input has its own enable, its own active level, and a choice between the raw pin and a sample filter. A detected fault forces the affected channels to their inactive level and sets a sticky flag. The block then resumes either automatically at a period boundary or after an explicit clear.

Top module: `pwm_pair_stage`

## Requirements
- R1: While reset is low and on the first edge after it, each pin equals `init_val ^ pol` for its channel, and `fault_flag` is 0.
- R2: With dead time off, channel 0 follows `ref_pwm`. Channel 1 follows `ref_pwm`, or its inverse when `comp_en` is 1. A change on `ref_pwm` appears on the pins one clock edge later.
- R3: With `dt_en` set, the rising edge of each channel is delayed by `dt_val × M` clocks, where `dt_pre` encodes M: 0→1, 1→4, 2 or 3→16. Falling edges are not delayed.
- R4: A high pulse on a channel that is shorter than the dead time never reaches that channel's pin.
- R5: `inv_en` inverts both channels after the dead-time stage.
- R6: When `sw_en[i]` is 1, channel i takes the value `sw_val[i]` in place of the waveform.
- R7: When `out_mask[i]` is 1, channel i goes to its inactive value, and the pin reads `pol[i]`. This overrides software override.
- R8: Fault input k is active when `fault_en[k]` is 1 and the selected signal differs from `fault_low[k]`; a 1 in `fault_low[k]` means a low level is a fault. Disabled inputs are ignored. An active fault forces the affected channels inactive on the next edge and sets `fault_flag`. This happens only when `fault_mode` is not 0 and `fault_pair_en` is 1.
- R9: With `fault_filt[k]` set, input k is taken through a filter. The filter changes its output only after 3 equal consecutive samples. A held fault therefore reaches the pins 5 edges after it is applied, and shorter pulses are ignored.
- R10: In manual modes (`fault_mode` 1 or 2), the shutdown and the flag remain until `fault_clr` is pulsed while no fault is active. A clear pulse sent while a fault is active is ignored. The pins resume 2 edges after the clear.
- R11: In automatic mode (`fault_mode` 3), the shutdown ends at a `period_start` pulse that arrives with no fault active, and the pins resume 2 edges later. `fault_flag` stays set until `fault_clr`.
- R12: When `fault_mode` is 1, a fault affects only channel 0.
- R13: Polarity is applied last. Each pin equals `value ^ pol[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pwm | input | 1 | Reference PWM waveform for the pair |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| comp_en | input | 1 | Channel 1 is the complement of the reference |
| dt_en | input | 1 | Enable dead-time insertion |
| dt_pre | input | 2 | Dead-time multiplier select (0:×1, 1:×4, 2/3:×16) |
| dt_val | input | DT_W | Dead-time count |
| inv_en | input | 1 | Invert both channels |
| sw_en | input | 2 | Software override enable per channel |
| sw_val | input | 2 | Software override value per channel |
| out_mask | input | 2 | Force channel inactive |
| pol | input | 2 | 1 = channel is active low |
| init_val | input | 2 | Channel value applied during reset |
| fault_in | input | NF | Fault input pins |
| fault_en | input | NF | Per-input enable |
| fault_low | input | NF | Per-input active-low select |
| fault_filt | input | NF | Per-input filtered path select |
| fault_mode | input | 2 | 0 off, 1 even channel manual, 2 all manual, 3 all automatic |
| fault_pair_en | input | 1 | Fault shutdown enable for this pair |
| fault_clr | input | 1 | Clear pulse for the fault flag and manual shutdown |
| pin | output | 2 | Pin levels, bit 0 is the even channel |
| fault_flag | output | 1 | Sticky fault flag |

## Verification
Most results reach the pins one edge after the stimulus, because only the output register lies on the path. A dead-time rise lands at 1 + `dt_val × M` edges. A filtered fault lands at 5 edges. A release lands at 2 edges after the clear or period pulse, because the hold register clears first. The flag moves on the first edge.

The driver records each expectation with the exact cycle in which it is due. It also records a cycle just before that, where the old value must still hold, so both early and late transitions are caught. The monitor compares the pins and the flag in the half cycle away from the clock edge.

// File: rtl/pwm_pair_pkg.sv
// Shared types for the PWM pair output stage.
package pwm_pair_pkg;

    typedef enum logic [1:0] {
        FLT_OFF      = 2'd0,
        FLT_EVEN_MAN = 2'd1,
        FLT_ALL_MAN  = 2'd2,
        FLT_ALL_AUTO = 2'd3
    } flt_mode_e;

    // Dead-time multiplier for a prescaler select code.
    function automatic logic [4:0] dt_mult(input logic [1:0] sel);
        case (sel)
            2'd0:    dt_mult = 5'd1;
            2'd1:    dt_mult = 5'd4;
            default: dt_mult = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/pp_dt_edge.sv
// Rising-edge delay for one channel.
// Output rises once the input has been high for `limit` clocks and falls with the input.
// A high pulse shorter than `limit` never appears on the output.
// Assumes: limit is quasi-static.
module pp_dt_edge #(
    parameter int LIM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [LIM_W-1:0] limit,
    output logic             dout
);

    logic [LIM_W-1:0] cnt_q;

    // Count the clocks the input has been high, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !din)
            cnt_q <= '0;
        else if (cnt_q < limit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign dout = din && (cnt_q >= limit);

    AST_DT_RISE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dout && !$past(dout) && (limit != '0) && $stable(limit)) |-> $past(din)); // R3

endmodule

// File: rtl/pp_flt_filter.sv
// Sample filter for one fault input.
// The output changes only after FILT_LEN equal consecutive samples.
module pp_flt_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [FILT_LEN-1:0] sr_q;
    logic                filt_q;

    // Shift in samples and update the output when all of them agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            filt_q <= 1'b0;
        end else begin
            sr_q <= {sr_q[FILT_LEN-2:0], din};
            if (&sr_q)
                filt_q <= 1'b1;
            else if (~|sr_q)
                filt_q <= 1'b0;
        end
    end

    assign dout = filt_q;

endmodule

// File: rtl/pp_fault_ctrl.sv
// Fault detection, sticky flag and shutdown hold for one channel pair.
// Produces a per-channel shutdown request.
// Assumes: fault_clr and period_start are single-cycle pulses.
module pp_fault_ctrl
    import pwm_pair_pkg::*;
#(
    parameter int NF       = 4,
    parameter int FILT_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] fault_in,
    input  logic [NF-1:0] fault_en,
    input  logic [NF-1:0] fault_low,
    input  logic [NF-1:0] fault_filt,
    input  flt_mode_e     mode,
    input  logic          pair_en,
    input  logic          fault_clr,
    input  logic          period_start,
    output logic [1:0]    shut,
    output logic          flag
);

    logic [NF-1:0] filt_v;
    logic [NF-1:0] active;
    logic          any_fault;
    logic          flag_q;
    logic          hold_q;
    logic          release_ok;
    logic          shut_all;

    for (genvar k = 0; k < NF; k++) begin : g_in
        pp_flt_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (fault_in[k]),
            .dout (filt_v[k])
        );
        // Choose the raw or filtered path, then apply the input's active level and enable.
        assign active[k] = fault_en[k] & ((fault_filt[k] ? filt_v[k] : fault_in[k]) ^ fault_low[k]);
    end

    assign any_fault  = (|active) && (mode != FLT_OFF);
    assign release_ok = (mode == FLT_ALL_AUTO) ? period_start : fault_clr;

    // Sticky flag: set by any fault, cleared by an explicit clear once the faults are gone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (any_fault)
            flag_q <= 1'b1;
        else if (fault_clr)
            flag_q <= 1'b0;
    end

    // Shutdown hold: released by a period start (automatic) or a clear (manual).
    always_ff @(posedge clk) begin
        if (!rst_n || mode == FLT_OFF)
            hold_q <= 1'b0;
        else if (any_fault)
            hold_q <= 1'b1;
        else if (release_ok)
            hold_q <= 1'b0;
    end

    assign shut_all = (any_fault | hold_q) & pair_en;
    assign shut[0]  = shut_all;
    assign shut[1]  = shut_all & (mode != FLT_EVEN_MAN);
    assign flag     = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !fault_clr) |=> flag_q); // R10
    AST_MAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && (mode == FLT_ALL_MAN || mode == FLT_EVEN_MAN) && !fault_clr) |=> hold_q); // R10
    AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && mode == FLT_ALL_AUTO && !period_start) |=> hold_q); // R11

endmodule

// File: rtl/pwm_pair_stage.sv
// Output stage for one complementary PWM channel pair.
// The stages, in order, are: complement, dead time, inversion, software override, mask,
// fault shutdown, polarity. The final pin level is registered.
// Assumes: configuration inputs are quasi-static, and the even channel is bit 0.
module pwm_pair_stage
    import pwm_pair_pkg::*;
#(
    parameter int DT_W     = 6,
    parameter int NF       = 4,
    parameter int FILT_LEN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_pwm,
    input  logic            period_start,
    input  logic            comp_en,
    input  logic            dt_en,
    input  logic [1:0]      dt_pre,
    input  logic [DT_W-1:0] dt_val,
    input  logic            inv_en,
    input  logic [1:0]      sw_en,
    input  logic [1:0]      sw_val,
    input  logic [1:0]      out_mask,
    input  logic [1:0]      pol,
    input  logic [1:0]      init_val,
    input  logic [NF-1:0]   fault_in,
    input  logic [NF-1:0]   fault_en,
    input  logic [NF-1:0]   fault_low,
    input  logic [NF-1:0]   fault_filt,
    input  logic [1:0]      fault_mode,
    input  logic            fault_pair_en,
    input  logic            fault_clr,
    output logic [1:0]      pin,
    output logic            fault_flag
);

    localparam int LIM_W = DT_W + 5;

    logic [LIM_W-1:0] dt_lim;
    logic [1:0]       base;
    logic [1:0]       dt_out;
    logic [1:0]       val;
    logic [1:0]       shut;
    logic [1:0]       pin_d;
    logic [1:0]       pin_q;

    // Dead-time length in clocks: count multiplied by the prescale factor.
    assign dt_lim = dt_en ? (LIM_W'(dt_val) * LIM_W'(dt_mult(dt_pre))) : '0;

    assign base[0] = ref_pwm;
    assign base[1] = comp_en ? ~ref_pwm : ref_pwm;

    pp_fault_ctrl #(.NF(NF), .FILT_LEN(FILT_LEN)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_in    (fault_in),
        .fault_en    (fault_en),
        .fault_low   (fault_low),
        .fault_filt  (fault_filt),
        .mode        (flt_mode_e'(fault_mode)),
        .pair_en     (fault_pair_en),
        .fault_clr   (fault_clr),
        .period_start(period_start),
        .shut        (shut),
        .flag        (fault_flag)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ch
        pp_dt_edge #(.LIM_W(LIM_W)) u_dt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (base[g]),
            .limit(dt_lim),
            .dout (dt_out[g])
        );

        // Priority chain from inversion up to polarity.
        always_comb begin
            val[g] = dt_out[g] ^ inv_en;
            if (sw_en[g])
                val[g] = sw_val[g];
            if (out_mask[g] || shut[g])
                val[g] = 1'b0;
            pin_d[g] = val[g] ^ pol[g];
        end

        AST_MASK_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(out_mask[g])) |-> (pin[g] == $past(pol[g]))); // R7
        AST_FAULT_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(shut[g])) |-> (pin[g] == $past(pol[g]))); // R8
    end

    // Output register: loads the initial state during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= init_val ^ pol;
        else
            pin_q <= pin_d;
    end

    assign pin = pin_q;

endmodule

// File: tb/pwm_pair_stage_tb.sv
module pwm_pair_stage_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int         due;
        logic [1:0] pins;
        logic       flag;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_pwm, period_start, comp_en, dt_en, inv_en;
    logic [1:0] dt_pre, sw_en, sw_val, out_mask, pol, init_val, fault_mode;
    logic [5:0] dt_val;
    logic [3:0] fault_in, fault_en, fault_low, fault_filt;
    logic       fault_pair_en, fault_clr;
    logic [1:0] pin;
    logic       fault_flag;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t q[$];

    pwm_pair_stage u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pwm(ref_pwm), .period_start(period_start),
        .comp_en(comp_en), .dt_en(dt_en), .dt_pre(dt_pre), .dt_val(dt_val),
        .inv_en(inv_en), .sw_en(sw_en), .sw_val(sw_val), .out_mask(out_mask),
        .pol(pol), .init_val(init_val), .fault_in(fault_in), .fault_en(fault_en),
        .fault_low(fault_low), .fault_filt(fault_filt), .fault_mode(fault_mode),
        .fault_pair_en(fault_pair_en), .fault_clr(fault_clr),
        .pin(pin), .fault_flag(fault_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expected pin/flag value due d edges from now.
    task automatic push_exp(input int d, input logic [1:0] p, input logic f, input string tag);
        exp_t e;
        e.due = cyc + d; e.pins = p; e.flag = f; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares due items in the half cycle away from the edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            checks++;
            if (pin !== q[0].pins || fault_flag !== q[0].flag) begin
                failures++;
                $display("FAIL %s cyc=%0d actual pin=%b flag=%b expected pin=%b flag=%b",
                         q[0].tag, cyc, pin, fault_flag, q[0].pins, q[0].flag);
            end
            void'(q.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc > WATCHDOG || done);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog cyc=%0d actual running expected finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ref_pwm = 0; period_start = 0; comp_en = 0; dt_en = 0; inv_en = 0;
        dt_pre = 0; dt_val = 0; sw_en = 0; sw_val = 0; out_mask = 0; pol = 0;
        init_val = 2'b10; fault_mode = 0; fault_in = 0; fault_en = 0; fault_low = 0;
        fault_filt = 0; fault_pair_en = 0; fault_clr = 0;

        // R1: initial state during reset
        wait_n(2);
        push_exp(1, 2'b10, 0, "R1 reset init");
        wait_n(2);
        rst_n = 1;
        push_exp(1, 2'b00, 0, "R2 after reset");
        wait_n(2);

        // R2: follow and complement
        ref_pwm = 1; push_exp(1, 2'b11, 0, "R2 follow high");
        wait_n(2);
        comp_en = 1; push_exp(1, 2'b01, 0, "R2 complement ref high");
        wait_n(2);
        ref_pwm = 0; push_exp(1, 2'b10, 0, "R2 complement ref low");
        wait_n(2);

        // R3: dead time x1, value 3
        dt_en = 1; dt_pre = 0; dt_val = 3;
        wait_n(6);
        ref_pwm = 1;
        push_exp(1, 2'b00, 0, "R3 fall immediate");
        push_exp(3, 2'b00, 0, "R3 rise held x1");
        push_exp(4, 2'b01, 0, "R3 rise x1");
        wait_n(8);
        ref_pwm = 0;
        push_exp(1, 2'b00, 0, "R3 fall immediate ch0");
        push_exp(3, 2'b00, 0, "R3 rise held ch1");
        push_exp(4, 2'b10, 0, "R3 rise ch1");
        wait_n(8);

        // R3: x4 prescale, value 2 -> 8 clocks
        dt_pre = 1; dt_val = 2;
        wait_n(12);
        ref_pwm = 1;
        push_exp(1, 2'b00, 0, "R3 x4 fall");
        push_exp(8, 2'b00, 0, "R3 x4 held");
        push_exp(9, 2'b01, 0, "R3 x4 rise");
        wait_n(12);
        ref_pwm = 0;
        push_exp(9, 2'b10, 0, "R3 x4 rise ch1");
        wait_n(12);

        // R4: 4-clock pulse against 8-clock dead time is suppressed
        ref_pwm = 1;
        push_exp(1, 2'b00, 0, "R4 short pulse");
        push_exp(4, 2'b00, 0, "R4 short pulse");
        wait_n(4);
        ref_pwm = 0;
        push_exp(1, 2'b00, 0, "R4 suppressed");
        push_exp(2, 2'b00, 0, "R4 suppressed");
        push_exp(8, 2'b00, 0, "R4 ch1 held");
        push_exp(9, 2'b10, 0, "R4 ch1 rise");
        wait_n(12);

        // R3: x16 prescale, value 1 -> 16 clocks
        dt_pre = 2; dt_val = 1;
        wait_n(20);
        ref_pwm = 1;
        push_exp(1, 2'b00, 0, "R3 x16 fall");
        push_exp(16, 2'b00, 0, "R3 x16 held");
        push_exp(17, 2'b01, 0, "R3 x16 rise");
        wait_n(20);
        ref_pwm = 0;
        push_exp(17, 2'b10, 0, "R3 x16 rise ch1");
        wait_n(20);
        dt_en = 0; push_exp(1, 2'b10, 0, "R2 dead time off");
        wait_n(2);

        // R5: inversion
        inv_en = 1; push_exp(1, 2'b01, 0, "R5 invert");
        wait_n(2);
        inv_en = 0; push_exp(1, 2'b10, 0, "R5 invert off");
        wait_n(2);

        // R6: software override
        sw_en = 2'b01; sw_val = 2'b01; push_exp(1, 2'b11, 0, "R6 override ch0");
        wait_n(2);
        ref_pwm = 1; push_exp(1, 2'b01, 0, "R6 ch0 ignores ref");
        wait_n(2);
        ref_pwm = 0; sw_en = 2'b10; sw_val = 2'b00; push_exp(1, 2'b00, 0, "R6 override ch1");
        wait_n(2);

        // R7: mask over override
        sw_en = 2'b11; sw_val = 2'b11; out_mask = 2'b01; push_exp(1, 2'b10, 0, "R7 mask ch0");
        wait_n(2);
        out_mask = 2'b00; push_exp(1, 2'b11, 0, "R7 unmask");
        wait_n(2);
        sw_en = 0; push_exp(1, 2'b10, 0, "R6 override off");
        wait_n(2);

        // R13: polarity
        pol = 2'b11; push_exp(1, 2'b01, 0, "R13 polarity");
        wait_n(2);
        out_mask = 2'b11; push_exp(1, 2'b11, 0, "R13 R7 masked with polarity");
        wait_n(2);
        out_mask = 0; pol = 0; push_exp(1, 2'b10, 0, "R13 polarity off");
        wait_n(2);

        // R8: faults, all channels, manual clearing
        fault_mode = 2; fault_pair_en = 1; fault_en = 4'b0010;
        fault_in = 4'b0001;
        push_exp(1, 2'b10, 0, "R8 disabled input ignored");
        push_exp(3, 2'b10, 0, "R8 disabled input ignored");
        wait_n(3);
        fault_in = 4'b0010; push_exp(1, 2'b00, 1, "R8 fault shutdown");
        wait_n(2);
        fault_clr = 1; push_exp(1, 2'b00, 1, "R10 clear ignored while active");
        wait_n(1);
        fault_clr = 0; fault_in = 0;
        push_exp(1, 2'b00, 1, "R10 hold after negate");
        push_exp(3, 2'b00, 1, "R10 hold after negate");
        wait_n(3);
        fault_clr = 1;
        push_exp(1, 2'b00, 0, "R10 flag cleared");
        push_exp(2, 2'b10, 0, "R10 resume");
        wait_n(1);
        fault_clr = 0;
        wait_n(2);

        // R8: active-low input
        fault_low = 4'b0010; push_exp(1, 2'b00, 1, "R8 active low fault");
        wait_n(2);
        fault_low = 0; push_exp(1, 2'b00, 1, "R10 hold after active low");
        wait_n(2);
        fault_clr = 1;
        push_exp(1, 2'b00, 0, "R10 clear");
        push_exp(2, 2'b10, 0, "R10 resume");
        wait_n(1);
        fault_clr = 0;
        wait_n(2);

        // R11: automatic clearing
        fault_mode = 3;
        fault_in = 4'b0010; push_exp(1, 2'b00, 1, "R11 auto fault");
        wait_n(2);
        period_start = 1; push_exp(1, 2'b00, 1, "R11 no release while active");
        wait_n(1);
        period_start = 0; fault_in = 0; push_exp(2, 2'b00, 1, "R11 hold until period");
        wait_n(3);
        period_start = 1;
        push_exp(1, 2'b00, 1, "R11 release edge");
        push_exp(2, 2'b10, 1, "R11 resume flag kept");
        wait_n(1);
        period_start = 0;
        wait_n(1);
        fault_clr = 1; push_exp(1, 2'b10, 0, "R11 flag clear");
        wait_n(1);
        fault_clr = 0;
        wait_n(1);

        // R12: even channel only
        fault_mode = 1;
        sw_en = 2'b11; sw_val = 2'b11; push_exp(1, 2'b11, 0, "R12 setup");
        wait_n(2);
        fault_in = 4'b0010; push_exp(1, 2'b10, 1, "R12 even only");
        wait_n(2);
        fault_in = 0;
        wait_n(1);
        fault_clr = 1;
        push_exp(1, 2'b10, 0, "R12 clear");
        push_exp(2, 2'b11, 0, "R12 resume");
        wait_n(1);
        fault_clr = 0;
        wait_n(1);
        sw_en = 0; push_exp(1, 2'b10, 0, "R12 override off");
        wait_n(2);

        // R9: filtered path
        fault_mode = 2; fault_filt = 4'b0010;
        fault_in = 4'b0010; push_exp(1, 2'b10, 0, "R9 short pulse");
        wait_n(2);
        fault_in = 0;
        push_exp(1, 2'b10, 0, "R9 short pulse ignored");
        push_exp(4, 2'b10, 0, "R9 short pulse ignored");
        wait_n(5);
        fault_in = 4'b0010;
        push_exp(4, 2'b10, 0, "R9 filter delay");
        push_exp(5, 2'b00, 1, "R9 filtered fault");
        wait_n(6);
        fault_in = 0;
        wait_n(8);
        fault_clr = 1;
        push_exp(1, 2'b00, 0, "R9 R10 clear");
        push_exp(2, 2'b10, 0, "R9 R10 resume");
        wait_n(1);
        fault_clr = 0;

        wait (q.size() == 0);
        wait_n(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule